// File: doc/BRIEF.md
# Radix-16 Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full `2*WIDTH`-bit product. Each clock cycle it retires one hexadecimal digit of the multiplier, starting with the least significant digit. The multiple of the multiplicand for that digit is built only from shifted copies of the multiplicand, added or subtracted. A sixteen-way select picks which shifts to combine. That multiple is then added into a double-width accumulator.

Between steps the remaining multiplier moves right by four bits. The multiplicand copy moves left by four bits, so each multiple lands at its proper weight of sixteen. The number of steps is fixed at `WIDTH/4`. A constant-length step counter therefore ends the operation, with no test on the data.

A client raises `start` for one cycle while the block is not running. `busy` then stays high for the digit steps. `done` pulses for one cycle afterwards, and `product` then holds its value until the next accepted start.

The controller has three states:
- `ST_IDLE`: waiting. An accepted `start` moves it to `ST_RUN`.
- `ST_RUN`: one digit per cycle. After the last digit it moves to `ST_FIN`.
- `ST_FIN`: `done` is high. With `start` it moves to `ST_RUN`; otherwise it returns to `ST_IDLE`.

Top module: `hexmul_radix16`

## Requirements
- R1: After reset `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is low latches `op_a` and `op_b`, clears the accumulator, and makes `busy` high from the next cycle.
- R3: `busy` stays high for exactly `WIDTH/4` consecutive cycles per operation, independent of operand values.
- R4: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low after a run.
- R5: When `done` is high, `product` equals `op_a * op_b` of the accepted operands, computed as unsigned numbers in `2*WIDTH` bits.
- R6: A multiplier digit value d (0 to 15) at hex position k (bits 4k+3 down to 4k) adds `op_a * d * 16^k`. This holds for every digit value and every position.
- R7: `start`, `op_a` and `op_b` are ignored while `busy` is high. The product and the run length stay those of the operation already accepted.
- R8: While `busy` and `start` are low, `product` does not change, even if the operand inputs change.
- R9: All-ones operands give (2^WIDTH - 1)^2 with no loss of upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| busy | output | 1 | Digit steps in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The assertions assume that `rst_n` is released synchronously and that `start`, `op_a` and `op_b` are never unknown while the block is out of reset. They also assume that the multiplicand copy never loses bits that the running product still needs. This follows from operands that are at most `WIDTH` bits and from `WIDTH` being a multiple of four. The bench drives every input only on the falling clock edge, and it keeps all operands inside their declared width. It sweeps a 4-bit instance exhaustively and an 8-bit instance over every multiplicand against a spread of multiplier patterns. It deliberately pulses `start` during a run, so the step-length and ignore properties are exercised.

// File: rtl/hexmul_pkg.sv
package hexmul_pkg;
    localparam int DIGIT_BITS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } hexmul_state_e;
endpackage

// File: rtl/hexmul_digit_mult.sv
module hexmul_digit_mult #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] mcand,
    input  logic [3:0]       digit,
    output logic [ACC_W-1:0] multiple
);
    // Sixteen shift-and-add recipes. Each result fits in ACC_W, so
    // subtraction in modulo arithmetic gives the exact value.
    always_comb begin
        unique case (digit)
            4'd0:  multiple = '0;
            4'd1:  multiple = mcand;
            4'd2:  multiple = mcand << 1;
            4'd3:  multiple = (mcand << 1) + mcand;
            4'd4:  multiple = mcand << 2;
            4'd5:  multiple = (mcand << 2) + mcand;
            4'd6:  multiple = (mcand << 2) + (mcand << 1);
            4'd7:  multiple = (mcand << 3) - mcand;
            4'd8:  multiple = mcand << 3;
            4'd9:  multiple = (mcand << 3) + mcand;
            4'd10: multiple = (mcand << 3) + (mcand << 1);
            4'd11: multiple = (mcand << 3) + (mcand << 1) + mcand;
            4'd12: multiple = (mcand << 3) + (mcand << 2);
            4'd13: multiple = (mcand << 3) + (mcand << 2) + mcand;
            4'd14: multiple = (mcand << 4) - (mcand << 1);
            4'd15: multiple = (mcand << 4) - mcand;
            default: multiple = '0;
        endcase
    end
endmodule

// File: rtl/hexmul_ctrl.sv
module hexmul_ctrl
    import hexmul_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);

    hexmul_state_e state_q, state_d;
    logic [CNT_W-1:0] step_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (step_cnt == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
        end else if (load) begin
            step_cnt <= '0;
        end else if (step) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FIN: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_follows_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/hexmul_datapath.sv
module hexmul_datapath #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    localparam int ACC_W = 2 * WIDTH;

    logic [ACC_W-1:0] mcand_sh;
    logic [WIDTH-1:0] mplier_sh;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] multiple;

    hexmul_digit_mult #(.ACC_W(ACC_W)) u_digit (
        .mcand    (mcand_sh),
        .digit    (mplier_sh[3:0]),
        .multiple (multiple)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_sh  <= '0;
            mplier_sh <= '0;
            acc       <= '0;
        end else if (load) begin
            mcand_sh  <= {{WIDTH{1'b0}}, op_a};
            mplier_sh <= op_b;
            acc       <= '0;
        end else if (step) begin
            acc       <= acc + multiple;
            mcand_sh  <= mcand_sh << 4;
            mplier_sh <= mplier_sh >> 4;
        end
    end

    assign product = acc;

    assert_digit_multiple_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (multiple == ACC_W'(mcand_sh * {{(ACC_W-4){1'b0}}, mplier_sh[3:0]})));
    assert_product_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(product));
endmodule

// File: rtl/hexmul_radix16.sv
module hexmul_radix16 #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    localparam int DIGITS = WIDTH / 4;
    localparam int RUN_W  = $clog2(DIGITS + 1) + 1;

    if ((WIDTH % 4) != 0 || WIDTH < 4) begin : g_bad_width
        $error("WIDTH must be a positive multiple of 4");
    end

    logic load, step;

    hexmul_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    hexmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    // Run-length monitor for the fixed step count
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RUN_W'(DIGITS)));
    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
endmodule

// File: tb/hexmul_radix16_bench.sv
module hexmul_radix16_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        st8 = 1'b0, st4 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        busy8, done8, busy4, done4;
    logic [15:0] p8;
    logic [7:0]  p4;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexmul_radix16 #(.WIDTH(8)) u_hexmul_radix16 (
        .clk(clk), .rst_n(rst_n), .start(st8), .op_a(a8), .op_b(b8),
        .busy(busy8), .done(done8), .product(p8));

    hexmul_radix16 #(.WIDTH(4)) u_hexmul_radix16_w4 (
        .clk(clk), .rst_n(rst_n), .start(st4), .op_a(a4), .op_b(b4),
        .busy(busy4), .done(done4), .product(p4));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One 8-bit operation; optional start pulse during the run (R7)
    task automatic run8(input logic [7:0] a, input logic [7:0] b, input bit poke, input string req);
        int cnt = 0;
        @(negedge clk);
        a8 = a; b8 = b; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        check(busy8 == 1'b1, "R2 busy after start", longint'(busy8), 1);
        while (busy8 && cnt < 50) begin
            if (poke && cnt == 1) begin
                st8 = 1'b1; a8 = 8'hFF; b8 = 8'hFF;
            end
            @(negedge clk);
            st8 = 1'b0;
            cnt++;
        end
        check(cnt == 2, "R3 busy length", cnt, 2);
        check(done8 == 1'b1, "R4 done after busy", longint'(done8), 1);
        check(p8 == 16'(a * b), req, longint'(p8), longint'(16'(a * b)));
        @(negedge clk);
        check(done8 == 1'b0, "R4 done one cycle", longint'(done8), 0);
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b, input string req);
        int cnt = 0;
        @(negedge clk);
        a4 = a; b4 = b; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        while (busy4 && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 1, "R3 busy length w4", cnt, 1);
        check(done4 == 1'b1, "R4 done w4", longint'(done4), 1);
        check(p4 == 8'(a * b), req, longint'(p4), longint'(8'(a * b)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy8 == 0 && done8 == 0, "R1 control reset", longint'({busy8, done8}), 0);
        check(p8 == 0, "R1 product reset", longint'(p8), 0);
        check(busy4 == 0 && p4 == 0, "R1 w4 reset", longint'(p4), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: all-ones
        run8(8'hFF, 8'hFF, 1'b0, "R9 all ones w8");
        run4(4'hF, 4'hF, "R9 all ones w4");

        // R5: exhaustive 4-bit sweep
        for (int i = 0; i < 256; i++) begin
            run4(4'(i >> 4), 4'(i), "R5 w4 sweep");
        end

        // R5: every multiplicand against spread multipliers
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 17) begin
                run8(8'(a), 8'(b), 1'b0, "R5 w8 sweep");
            end
        end

        // R6: each digit value at each position
        for (int d = 0; d < 16; d++) begin
            for (int k = 0; k < 2; k++) begin
                run8(8'hFF, 8'(d << (4 * k)), 1'b0, "R6 digit ff");
                run8(8'hA5, 8'(d << (4 * k)), 1'b0, "R6 digit a5");
            end
        end

        // R7: start during run is ignored
        run8(8'h9B, 8'hE7, 1'b1, "R7 start ignored");

        // R8: product holds while idle with changing inputs
        held = p8;
        for (int i = 0; i < 5; i++) begin
            a8 = 8'(i * 37); b8 = 8'(i * 91);
            @(negedge clk);
            check(p8 == held, "R8 idle hold", longint'(p8), longint'(held));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule